// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a small 32-bit RISC core. Software sees sixteen registers, index 0 to 15, and index 15 stands for the program counter. Which physical storage word an index reaches depends on the operating mode, which is held in the low five bits of a current status word kept inside the block. The fast-interrupt mode has private copies of registers 8 to 14. The other four exception modes (normal interrupt, supervisor, abort, undefined) each have a private stack pointer and link register (indices 13 and 14). The user and system modes share one plain bank.

Two combinational read ports and one synchronous write port serve the datapath. Reading index 15 returns the supplied program counter, and writing it has no effect. Each exception mode also owns a saved status word, which the datapath reads and writes for the current mode. A separate exception-entry port loads the link register and saved status of any target mode in one cycle. The current status word has its own load port. Every port is a plain enable-qualified port. The block accepts each operation in the cycle it is presented and never applies back-pressure, so no valid/ready handshake exists.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register and every saved status word reads 0, and the current status word reads 0x00000013 (supervisor mode).
- R2: A read of index 15 on either read port returns `pc_i` in the same cycle, and a general write to index 15 changes no register.
- R3: Modes 10000 (user) and 11111 (system) address the same storage for indices 0 to 14, so a value written in one mode is read back in the other.
- R4: Mode 10001 (fast interrupt) has private storage for indices 8 to 14 and shares indices 0 to 7 with user mode.
- R5: Modes 10010 (normal interrupt), 10011 (supervisor), 10111 (abort) and 11011 (undefined) each have private storage for indices 13 and 14 and share indices 0 to 12 with user mode.
- R6: A general write takes effect at the next rising clock edge. A read of the same register in the write cycle returns the old value.
- R7: Each of the five exception modes has its own saved status word. `spsr_o` shows the word of the current mode, and `spsr_we` loads it at the next edge.
- R8: In user, system or any unlisted mode, `spsr_o` equals `cpsr_o` and `spsr_we` changes no saved status word.
- R9: The exception port (`exc_we`) writes `exc_lr` into index 14 of the bank for `exc_mode` and `exc_spsr` into that mode's saved status word, whatever the current mode. For a mode without a saved status word, only the link value is written.
- R10: When the exception port and a general or saved-status write hit the same storage in one cycle, the exception port's value is kept.
- R11: `cpsr_we` loads `cpsr_wdata` into the current status word at the next edge. Bits 4:0 of that word select the mode for all register and saved-status accesses from that edge on.
- R12: Any mode encoding not listed above addresses the user bank, also as an exception-port target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Program counter value returned for index 15 |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write index |
| wr_data | input | 32 | General write data |
| cpsr_we | input | 1 | Current status load enable |
| cpsr_wdata | input | 32 | Current status load value |
| cpsr_o | output | 32 | Current status word; bits 4:0 are the mode |
| spsr_we | input | 1 | Saved status write enable for the current mode |
| spsr_wdata | input | 32 | Saved status write value |
| spsr_o | output | 32 | Saved status of current mode, or current status when none |
| exc_we | input | 1 | Exception-entry write enable |
| exc_mode | input | 5 | Target mode of the exception-entry write |
| exc_lr | input | 32 | Link value for the target mode's index 14 |
| exc_spsr | input | 32 | Saved status value for the target mode |

## Verification
The bench builds the block with its default 32-bit data width and the supervisor reset mode. At that width the random values cover every bit of each storage word and the full flag field of the status word. Random mode changes move among all seven legal encodings and one unlisted encoding, so every bank boundary (index 7/8, 12/13, 14/15) is crossed from each mode. Directed steps add collisions between the exception port and the general and saved-status writes in the same cycle, and same-cycle read-after-write.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

  localparam int MODE_W = 5;
  localparam int IDX_W  = 4;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'b10000,
    M_FIQ = 5'b10001,
    M_IRQ = 5'b10010,
    M_SVC = 5'b10011,
    M_ABT = 5'b10111,
    M_UND = 5'b11011,
    M_SYS = 5'b11111
  } mode_e;

  // Register layout
  localparam int PC_IDX    = 15;
  localparam int USR_N     = 15;               // r0..r14 shared bank
  localparam int FIQ_LO    = 8;                // fast-interrupt banks r8..r14
  localparam int FIQ_N     = USR_N - FIQ_LO;
  localparam int PRIV_LO   = 13;               // sp/lr banked in other exception modes
  localparam int PRIV_N    = USR_N - PRIV_LO;
  localparam int PRIV_MODES = 4;
  localparam int FIQ_BASE  = USR_N;
  localparam int PRIV_BASE = FIQ_BASE + FIQ_N;
  localparam int PHYS_N    = PRIV_BASE + PRIV_MODES * PRIV_N;
  localparam int PHYS_W    = $clog2(PHYS_N);

  localparam int SPSR_N = 5;
  localparam int SPSR_W = $clog2(SPSR_N);

  typedef struct packed {
    logic              hit;
    logic [SPSR_W-1:0] slot;
  } spsr_sel_t;

  // Which of the four sp/lr-banked modes, or -1
  function automatic int priv_slot(logic [MODE_W-1:0] m);
    case (m)
      M_IRQ:   return 0;
      M_SVC:   return 1;
      M_ABT:   return 2;
      M_UND:   return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [PHYS_W-1:0] phys_of(logic [MODE_W-1:0] m, logic [IDX_W-1:0] idx);
    int base;
    int ps;
    base = int'(idx);
    ps   = priv_slot(m);
    if (m == M_FIQ && base >= FIQ_LO && base < USR_N)
      base = FIQ_BASE + base - FIQ_LO;
    else if (ps >= 0 && base >= PRIV_LO && base < USR_N)
      base = PRIV_BASE + ps * PRIV_N + base - PRIV_LO;
    return PHYS_W'(base);
  endfunction

  function automatic spsr_sel_t spsr_of(logic [MODE_W-1:0] m);
    spsr_sel_t s;
    s.hit = 1'b1;
    case (m)
      M_FIQ:   s.slot = SPSR_W'(0);
      M_IRQ:   s.slot = SPSR_W'(1);
      M_SVC:   s.slot = SPSR_W'(2);
      M_ABT:   s.slot = SPSR_W'(3);
      M_UND:   s.slot = SPSR_W'(4);
      default: begin s.hit = 1'b0; s.slot = '0; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rfb_map.sv
module rfb_map
  import rfb_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);
  always_comb phys = phys_of(mode, idx);
endmodule

// File: rtl/rfb_gpr_array.sv
module rfb_gpr_array
  import rfb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_we,
  input  logic [PHYS_W-1:0] gen_addr,
  input  logic [DATA_W-1:0] gen_data,
  input  logic              exc_we,
  input  logic [PHYS_W-1:0] exc_addr,
  input  logic [DATA_W-1:0] exc_data,
  input  logic [PHYS_W-1:0] rd_addr_a,
  input  logic [PHYS_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);

  logic [DATA_W-1:0] mem [PHYS_N];

  generate
    for (genvar i = 0; i < PHYS_N; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[i] <= '0;
        else if (exc_we && exc_addr == PHYS_W'(i))
          mem[i] <= exc_data;
        else if (gen_we && gen_addr == PHYS_W'(i))
          mem[i] <= gen_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    if (int'(rd_addr_a) < PHYS_N) rd_data_a = mem[rd_addr_a];
    if (int'(rd_addr_b) < PHYS_N) rd_data_b = mem[rd_addr_b];
  end

endmodule

// File: rtl/rfb_psr_unit.sv
module rfb_psr_unit
  import rfb_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [MODE_W-1:0] RESET_MODE = M_SVC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  output logic [DATA_W-1:0] cpsr,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] spsr,
  input  logic              exc_we,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic [DATA_W-1:0] exc_spsr
);

  logic [DATA_W-1:0] saved [SPSR_N];
  spsr_sel_t cur_sel;
  spsr_sel_t exc_sel;

  always_comb begin
    cur_sel = spsr_of(cpsr[MODE_W-1:0]);
    exc_sel = spsr_of(exc_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cpsr <= DATA_W'(RESET_MODE);
    else if (cpsr_we)
      cpsr <= cpsr_wdata;
  end

  generate
    for (genvar s = 0; s < SPSR_N; s++) begin : g_saved
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          saved[s] <= '0;
        else if (exc_we && exc_sel.hit && exc_sel.slot == SPSR_W'(s))
          saved[s] <= exc_spsr;
        else if (spsr_we && cur_sel.hit && cur_sel.slot == SPSR_W'(s))
          saved[s] <= spsr_wdata;
      end
    end
  endgenerate

  always_comb begin
    spsr = cpsr;
    if (cur_sel.hit && int'(cur_sel.slot) < SPSR_N) spsr = saved[cur_sel.slot];
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rfb_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [MODE_W-1:0] RESET_MODE = M_SVC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  output logic [DATA_W-1:0] cpsr_o,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] spsr_o,
  input  logic              exc_we,
  input  logic [MODE_W-1:0] exc_mode,
  input  logic [DATA_W-1:0] exc_lr,
  input  logic [DATA_W-1:0] exc_spsr
);

  localparam int LOOKUPS = 4;  // read A, read B, general write, exception link
  localparam int LK_RA = 0, LK_RB = 1, LK_WR = 2, LK_EX = 3;
  localparam logic [IDX_W-1:0] PC_I = IDX_W'(PC_IDX);
  localparam logic [IDX_W-1:0] LR_I = IDX_W'(USR_N - 1);

  logic [MODE_W-1:0] cur_mode;
  logic [MODE_W-1:0] lk_mode [LOOKUPS];
  logic [IDX_W-1:0]  lk_idx  [LOOKUPS];
  logic [PHYS_W-1:0] lk_phys [LOOKUPS];
  logic [DATA_W-1:0] arr_a, arr_b;

  assign cur_mode = cpsr_o[MODE_W-1:0];

  always_comb begin
    lk_mode[LK_RA] = cur_mode;  lk_idx[LK_RA] = rd_a_idx;
    lk_mode[LK_RB] = cur_mode;  lk_idx[LK_RB] = rd_b_idx;
    lk_mode[LK_WR] = cur_mode;  lk_idx[LK_WR] = wr_idx;
    lk_mode[LK_EX] = exc_mode;  lk_idx[LK_EX] = LR_I;
  end

  generate
    for (genvar k = 0; k < LOOKUPS; k++) begin : g_lookup
      rfb_map u_map (
        .mode (lk_mode[k]),
        .idx  (lk_idx[k]),
        .phys (lk_phys[k])
      );
    end
  endgenerate

  rfb_gpr_array #(.DATA_W(DATA_W)) u_gpr (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_we    (wr_en && wr_idx != PC_I),
    .gen_addr  (lk_phys[LK_WR]),
    .gen_data  (wr_data),
    .exc_we    (exc_we),
    .exc_addr  (lk_phys[LK_EX]),
    .exc_data  (exc_lr),
    .rd_addr_a (lk_phys[LK_RA]),
    .rd_addr_b (lk_phys[LK_RB]),
    .rd_data_a (arr_a),
    .rd_data_b (arr_b)
  );

  rfb_psr_unit #(.DATA_W(DATA_W), .RESET_MODE(RESET_MODE)) u_psr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpsr_we    (cpsr_we),
    .cpsr_wdata (cpsr_wdata),
    .cpsr       (cpsr_o),
    .spsr_we    (spsr_we),
    .spsr_wdata (spsr_wdata),
    .spsr       (spsr_o),
    .exc_we     (exc_we),
    .exc_mode   (exc_mode),
    .exc_spsr   (exc_spsr)
  );

  always_comb begin
    rd_a_data = (rd_a_idx == PC_I) ? pc_i : arr_a;
    rd_b_data = (rd_b_idx == PC_I) ? pc_i : arr_b;
  end

endmodule

// File: rtl/rfb_checker.sv
module rfb_checker
  import rfb_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [MODE_W-1:0] RESET_MODE = M_SVC
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] pc_i,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              cpsr_we,
  input logic [DATA_W-1:0] cpsr_wdata,
  input logic [DATA_W-1:0] cpsr_o,
  input logic [DATA_W-1:0] spsr_o,
  input logic              exc_we
);

  logic no_saved;
  assign no_saved = (cpsr_o[MODE_W-1:0] == M_USR) || (cpsr_o[MODE_W-1:0] == M_SYS);

  a_r1_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> cpsr_o == DATA_W'(RESET_MODE));

  a_r2_pc_port_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 4'hF |-> rd_a_data == pc_i);

  a_r2_pc_port_b: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_idx == 4'hF |-> rd_b_data == pc_i);

  a_r6_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 4'hF && !exc_we && !cpsr_we) |=>
      (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

  a_r8_spsr_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    no_saved |-> spsr_o == cpsr_o);

  a_r11_cpsr_load: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we |=> cpsr_o == $past(cpsr_wdata));

endmodule

bind banked_regfile rfb_checker #(.DATA_W(DATA_W), .RESET_MODE(RESET_MODE)) i_rfb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_i       (pc_i),
  .rd_a_idx   (rd_a_idx),
  .rd_a_data  (rd_a_data),
  .rd_b_idx   (rd_b_idx),
  .rd_b_data  (rd_b_data),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .cpsr_we    (cpsr_we),
  .cpsr_wdata (cpsr_wdata),
  .cpsr_o     (cpsr_o),
  .spsr_o     (spsr_o),
  .exc_we     (exc_we)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, cpsr_o, spsr_o;
  logic        wr_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0, exc_we = 1'b0;
  logic [31:0] wr_data = '0, cpsr_wdata = '0, spsr_wdata = '0, exc_lr = '0, exc_spsr = '0;
  logic [4:0]  exc_mode = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_o(cpsr_o),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_o(spsr_o),
    .exc_we(exc_we), .exc_mode(exc_mode), .exc_lr(exc_lr), .exc_spsr(exc_spsr)
  );

  // Reference state, kept per visible bank as the requirements describe it
  logic [31:0] m_usr  [0:14];
  logic [31:0] m_fiq  [0:6];
  logic [31:0] m_sp_lr[0:3][0:1];
  logic [31:0] m_saved[0:4];
  logic [31:0] m_cpsr;

  // staged stimulus for the next step
  logic [3:0]  s_ra, s_rb, s_widx;
  logic        s_we, s_cwe, s_swe, s_ewe;
  logic [31:0] s_wd, s_cwd, s_swd, s_elr, s_esp;
  logic [4:0]  s_emode;

  function automatic int two_reg_mode(logic [4:0] m);
    if (m == 5'b10010) return 0;
    if (m == 5'b10011) return 1;
    if (m == 5'b10111) return 2;
    if (m == 5'b11011) return 3;
    return -1;
  endfunction

  function automatic int saved_of(logic [4:0] m);
    if (m == 5'b10001) return 0;
    if (two_reg_mode(m) >= 0) return two_reg_mode(m) + 1;
    return -1;
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] m, logic [3:0] i);
    int k;
    k = two_reg_mode(m);
    if (i == 4'd15) return pc_i;
    if (m == 5'b10001 && i >= 4'd8) return m_fiq[int'(i) - 8];
    if (k >= 0 && i >= 4'd13) return m_sp_lr[k][int'(i) - 13];
    return m_usr[i];
  endfunction

  function automatic void model_write(logic [4:0] m, logic [3:0] i, logic [31:0] d);
    int k;
    k = two_reg_mode(m);
    if (i == 4'd15) return;
    if (m == 5'b10001 && i >= 4'd8) m_fiq[int'(i) - 8] = d;
    else if (k >= 0 && i >= 4'd13) m_sp_lr[k][int'(i) - 13] = d;
    else m_usr[i] = d;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic clear_stage();
    s_ra = '0; s_rb = '0; s_widx = '0; s_we = 0; s_cwe = 0; s_swe = 0; s_ewe = 0;
    s_wd = '0; s_cwd = '0; s_swd = '0; s_elr = '0; s_esp = '0; s_emode = '0;
  endtask

  // One clock: drive at falling edge, check pre-edge state, update model after rising edge
  task automatic step(string tag);
    logic [4:0] cm;
    int sl;
    @(negedge clk);
    pc_i = $urandom();
    rd_a_idx = s_ra; rd_b_idx = s_rb;
    wr_en = s_we; wr_idx = s_widx; wr_data = s_wd;
    cpsr_we = s_cwe; cpsr_wdata = s_cwd;
    spsr_we = s_swe; spsr_wdata = s_swd;
    exc_we = s_ewe; exc_mode = s_emode; exc_lr = s_elr; exc_spsr = s_esp;
    #1;
    cm = m_cpsr[4:0];
    sl = saved_of(cm);
    check(tag, "read A", rd_a_data, exp_read(cm, s_ra));
    check(tag, "read B", rd_b_data, exp_read(cm, s_rb));
    check(tag, "cpsr",   cpsr_o, m_cpsr);
    check(tag, "spsr",   spsr_o, (sl >= 0) ? m_saved[sl] : m_cpsr);
    @(posedge clk);
    if (s_we) model_write(cm, s_widx, s_wd);
    if (s_swe && sl >= 0) m_saved[sl] = s_swd;
    if (s_ewe) begin
      model_write(s_emode, 4'd14, s_elr);
      if (saved_of(s_emode) >= 0) m_saved[saved_of(s_emode)] = s_esp;
    end
    if (s_cwe) m_cpsr = s_cwd;
    clear_stage();
  endtask

  task automatic go_mode(string tag, logic [4:0] m);
    s_cwe = 1; s_cwd = {$urandom() & 32'hF800_0000} | {27'd0, m};
    step(tag);
  endtask

  task automatic wr(string tag, logic [3:0] i, logic [31:0] d);
    s_we = 1; s_widx = i; s_wd = d; s_ra = i; s_rb = i;
    step(tag);
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [3:0] b);
    s_ra = a; s_rb = b;
    step(tag);
  endtask

  function automatic logic [4:0] pick_mode();
    case ($urandom_range(0, 7))
      0: return 5'b10000;
      1: return 5'b10001;
      2: return 5'b10010;
      3: return 5'b10011;
      4: return 5'b10111;
      5: return 5'b11011;
      6: return 5'b11111;
      default: return 5'b00101;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 15; i++) m_usr[i] = '0;
    for (int i = 0; i < 7; i++) m_fiq[i] = '0;
    for (int k = 0; k < 4; k++) begin m_sp_lr[k][0] = '0; m_sp_lr[k][1] = '0; end
    for (int s = 0; s < 5; s++) m_saved[s] = '0;
    m_cpsr = 32'h0000_0013;
    clear_stage();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset contents, supervisor mode
    for (int i = 0; i < 15; i += 2) rd("R1", 4'(i), 4'(i + 1));

    // R3 / R6: fill the user bank, read it from system mode
    go_mode("R11", 5'b10000);
    for (int i = 0; i < 15; i++) wr("R6", 4'(i), 32'hA000_0100 + i);
    go_mode("R11", 5'b11111);
    for (int i = 0; i < 15; i++) rd("R3", 4'(i), 4'(14 - i));

    // R8: saved-status write ignored in system mode, fallback to current status
    s_swe = 1; s_swd = 32'hDEAD_BEEF; step("R8");
    rd("R8", 4'd0, 4'd1);

    // R4: fast-interrupt private r8..r14
    go_mode("R11", 5'b10001);
    for (int i = 8; i < 15; i++) wr("R4", 4'(i), 32'hF1F0_0000 + i);
    for (int i = 0; i < 15; i++) rd("R4", 4'(i), 4'(i));
    s_swe = 1; s_swd = 32'h1111_2222; step("R7");
    go_mode("R11", 5'b10000);
    for (int i = 8; i < 15; i++) rd("R4", 4'(i), 4'(i));

    // R5 / R7: each two-register mode
    begin
      logic [4:0] ml [4] = '{5'b10010, 5'b10011, 5'b10111, 5'b11011};
      foreach (ml[k]) begin
        go_mode("R11", ml[k]);
        wr("R5", 4'd13, 32'h5000_0013 + (k << 8));
        wr("R5", 4'd14, 32'h5000_0014 + (k << 8));
        wr("R5", 4'd12, 32'h5000_0012 + (k << 8));
        s_swe = 1; s_swd = 32'h7000_0000 + k; step("R7");
        rd("R7", 4'd13, 4'd14);
      end
      go_mode("R11", 5'b10000);
      rd("R5", 4'd12, 4'd13);
      rd("R5", 4'd14, 4'd11);
      foreach (ml[k]) begin
        go_mode("R11", ml[k]);
        rd("R5", 4'd13, 4'd14);
      end
    end

    // R2: program counter on index 15, writes to it dropped
    rd("R2", 4'd15, 4'd15);
    wr("R2", 4'd15, 32'hBAD0_000F);
    rd("R2", 4'd15, 4'd14);

    // R6: same-cycle read returns old value
    s_we = 1; s_widx = 4'd3; s_wd = 32'h0303_0303; s_ra = 4'd3; s_rb = 4'd3; step("R6");
    rd("R6", 4'd3, 4'd3);

    // R9 / R10: exception port from user mode, then collisions in supervisor mode
    go_mode("R11", 5'b10000);
    s_ewe = 1; s_emode = 5'b10111; s_elr = 32'hE0E0_0001; s_esp = 32'hE5E5_0001; step("R9");
    s_ewe = 1; s_emode = 5'b11111; s_elr = 32'hE0E0_0002; s_esp = 32'hE5E5_0002; step("R9");
    rd("R9", 4'd14, 4'd13);
    go_mode("R11", 5'b10111);
    rd("R9", 4'd14, 4'd13);
    go_mode("R11", 5'b10011);
    s_we = 1; s_widx = 4'd14; s_wd = 32'h1234_5678;
    s_swe = 1; s_swd = 32'h8765_4321;
    s_ewe = 1; s_emode = 5'b10011; s_elr = 32'hCAFE_0014; s_esp = 32'hCAFE_5555;
    step("R10");
    rd("R10", 4'd14, 4'd14);

    // R12: unlisted encoding uses the user bank and has no saved status
    go_mode("R11", 5'b00101);
    wr("R12", 4'd13, 32'h0C0C_0013);
    s_swe = 1; s_swd = 32'h0BAD_0BAD; step("R12");
    s_ewe = 1; s_emode = 5'b01010; s_elr = 32'h0C0C_0014; s_esp = 32'h0; step("R12");
    go_mode("R11", 5'b10000);
    rd("R12", 4'd13, 4'd14);

    // random mix
    for (int n = 0; n < 600; n++) begin
      s_ra = 4'($urandom()); s_rb = 4'($urandom());
      s_we = ($urandom_range(0, 3) != 0); s_widx = 4'($urandom()); s_wd = $urandom();
      s_swe = ($urandom_range(0, 5) == 0); s_swd = $urandom();
      s_ewe = ($urandom_range(0, 7) == 0); s_emode = pick_mode(); s_elr = $urandom(); s_esp = $urandom();
      if ($urandom_range(0, 4) == 0) begin
        s_cwe = 1; s_cwd = ($urandom() & 32'hFFFF_FFE0) | {27'd0, pick_mode()};
      end
      step("R6");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule